// File: doc/BRIEF.md
# Convergence-Detecting Traceback Controller

This block is the survivor-path end of a Viterbi decoder. It does not include the add-compare-select stage. Each trellis step, that stage hands over one decision vector. The vector has one bit per state, and the bit says which of the state's two predecessors survived. The handover uses a request and acknowledge pair. The block writes each vector into a circular survivor memory. It also keeps a stored path, which is one trellis state per column, in a second small memory.

For every new column after start-up, the block traces back one column per clock cycle. It always starts from a fixed start state. At each step it compares the traced predecessor with the stored entry for that column:

- If the two differ, the stored entry is replaced and tracing continues.
- If they agree, the two paths have merged. Everything older in the stored path is already correct, so tracing stops and the remaining memory reads are skipped.

The acknowledge is returned only once the trace has ended. The same cycle carries one decoded bit, taken from the oldest column.

Before any of this, the memory must be filled. The first depth-minus-one columns are only stored. The column that completes the buffer triggers one full-depth initial trace with the comparison switched off. The default configuration has constraint length 3 (four states) and a depth of five times the constraint length, which is 15 columns.

Top module: `cvg_traceback`

## Requirements
- R1: During and straight after reset, `ackOut` and `bitValid` are 0.
- R2: Each of the first DEPTH-1 columns is only stored. `ackOut` rises in the cycle after the accepting edge, with `bitValid` = 0.
- R3: The column that completes the buffer starts a full trace of exactly DEPTH-1 steps with no comparison, then acknowledges with `bitValid` = 1.
- R4: A trace starts at state START_STATE in the newest column. Each step computes the predecessor as ((state << 1) | decision bit at index `state` of that column) masked to K-1 bits.
- R5: After start-up, the trace stops at the first step whose predecessor equals the stored entry of that older column. `ackOut` follows n cycles after the accepting edge, where n is the number of steps taken.
- R6: On a mismatch, the stored entry is overwritten with the traced predecessor, and later decoded bits reflect the new path.
- R7: A trace that finds no match stops after DEPTH-1 steps and acknowledges anyway.
- R8: `bitValid` is high only together with `ackOut`. `bitOut` is the most significant bit of the stored state of the oldest column, which is the one written DEPTH-1 columns before the current one.
- R9: `ackOut` is a single-cycle pulse followed by an idle cycle. A column is accepted only when the block is idle and `reqIn` is 1, and `reqIn` must stay high until the acknowledge.
- R10: While idle with `reqIn` low, neither memory changes, whatever `decIn` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 1 | Request: a new decision vector is on `decIn` |
| decIn | input | NUM_STATES | Decision vector, bit i for state i |
| ackOut | output | 1 | One-cycle acknowledge when the column is finished |
| bitValid | output | 1 | `bitOut` carries a decoded bit this cycle |
| bitOut | output | 1 | Decoded bit from the oldest column |

## Verification
Every result of this block falls due a fixed number of cycles after the clock edge that accepts a column:

- During fill, the acknowledge and decoded bit appear after that edge alone.
- Otherwise they appear n cycles after it, where n is the number of traceback steps. n is 1 when the paths merge at once and DEPTH-1 for the initial or non-merging trace.

The bench's behavioural model computes n and the expected bit before driving the request. The bench then checks `ackOut` low on every intermediate half-cycle and checks acknowledge, valid and bit at exactly the n-th one. Directed decision patterns force immediate merging, full-depth divergence and path rewrites. An idle stretch with a toggling `decIn` shows that nothing is disturbed.

// File: rtl/cvg_tb_pkg.sv
package cvg_tb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_TRACE,
    PH_FINISH
  } phase_t;

  // strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic colWrite;   // store incoming column, set up trace
    logic traceStep;  // one traceback step
    logic colDone;    // close the column, advance write pointer
  } strobe_t;

endpackage

// File: rtl/cvg_tb_ctrl.sv
module cvg_tb_ctrl
  import cvg_tb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqIn,
  input  logic    needTrace,
  input  logic    traceEnd,
  output strobe_t strobes,
  output logic    ackOut,
  output logic    isIdle
);

  phase_t phase, phaseNext;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE:   if (reqIn) phaseNext = needTrace ? PH_TRACE : PH_FINISH;
      PH_TRACE:  if (traceEnd) phaseNext = PH_FINISH;
      PH_FINISH: phaseNext = PH_IDLE;
      default:   phaseNext = PH_IDLE;
    endcase
  end

  always_comb begin
    strobes.colWrite  = (phase == PH_IDLE) && reqIn;
    strobes.traceStep = (phase == PH_TRACE);
    strobes.colDone   = (phase == PH_FINISH);
  end

  assign ackOut = (phase == PH_FINISH);
  assign isIdle = (phase == PH_IDLE);

endmodule

// File: rtl/cvg_tb_path.sv
module cvg_tb_path
  import cvg_tb_pkg::*;
#(
  parameter int MEM_BITS    = 2,
  parameter int DEPTH       = 15,
  parameter int START_STATE = 0,
  localparam int NS         = 1 << MEM_BITS,
  localparam int PW         = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strobes,
  input  logic [NS-1:0]             decIn,
  output logic                      needTrace,
  output logic                      traceEnd,
  output logic                      bitValid,
  output logic                      bitOut,
  output logic [DEPTH*NS-1:0]       survFlat,
  output logic [DEPTH*MEM_BITS-1:0] pathFlat
);

  localparam logic [PW-1:0]       LAST_IDX  = PW'(DEPTH - 1);
  localparam logic [PW-1:0]       LAST_STEP = PW'(DEPTH - 2);
  localparam logic [MEM_BITS-1:0] START_ST  = MEM_BITS'(START_STATE);

  logic [NS-1:0]       survMem [DEPTH];
  logic [MEM_BITS-1:0] pathMem [DEPTH];

  logic [PW-1:0]       wrPtr, rdPtr, stepCnt, fillCnt;
  logic [MEM_BITS-1:0] curState;
  logic                primed, initMode, decodeEn;

  // traceback step, combinational part
  logic                decBit;
  logic [MEM_BITS:0]   predWide;
  logic [MEM_BITS-1:0] predState;
  logic [PW-1:0]       prevPtr, nextWr;
  logic                storedMatch;

  assign decBit      = survMem[rdPtr][curState];
  assign predWide    = {curState, decBit};
  assign predState   = predWide[MEM_BITS-1:0];
  assign prevPtr     = (rdPtr == '0) ? LAST_IDX : rdPtr - 1'b1;
  assign storedMatch = !initMode && (pathMem[prevPtr] == predState);
  assign traceEnd    = storedMatch || (stepCnt == LAST_STEP);
  assign needTrace   = primed || (fillCnt == LAST_IDX);
  assign nextWr      = (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;

  // oldest column sits right after the newest in the ring
  assign bitOut   = pathMem[nextWr][MEM_BITS-1];
  assign bitValid = strobes.colDone && decodeEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        survMem[i] <= '0;
        pathMem[i] <= '0;
      end
      wrPtr    <= '0;
      rdPtr    <= '0;
      stepCnt  <= '0;
      fillCnt  <= '0;
      curState <= '0;
      primed   <= 1'b0;
      initMode <= 1'b0;
      decodeEn <= 1'b0;
    end else begin
      if (strobes.colWrite) begin
        survMem[wrPtr] <= decIn;
        decodeEn       <= needTrace;
        if (needTrace) begin
          pathMem[wrPtr] <= START_ST;
          curState       <= START_ST;
          rdPtr          <= wrPtr;
          stepCnt        <= '0;
          initMode       <= !primed;
        end else begin
          fillCnt <= fillCnt + 1'b1;
        end
      end
      if (strobes.traceStep) begin
        if (!storedMatch) pathMem[prevPtr] <= predState;
        curState <= predState;
        rdPtr    <= prevPtr;
        stepCnt  <= stepCnt + 1'b1;
      end
      if (strobes.colDone) begin
        wrPtr <= nextWr;
        if (decodeEn) primed <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign survFlat[g*NS +: NS]             = survMem[g];
    assign pathFlat[g*MEM_BITS +: MEM_BITS] = pathMem[g];
  end

endmodule

// File: rtl/cvg_traceback.sv
module cvg_traceback
  import cvg_tb_pkg::*;
#(
  parameter int CONSTRAINT_LEN = 3,
  parameter int DEPTH_MULT     = 5,
  parameter int START_STATE    = 0,
  localparam int NUM_STATES    = 1 << (CONSTRAINT_LEN - 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqIn,
  input  logic [NUM_STATES-1:0] decIn,
  output logic                  ackOut,
  output logic                  bitValid,
  output logic                  bitOut
);

  localparam int MEM_BITS    = CONSTRAINT_LEN - 1;
  localparam int DEPTH_TOTAL = DEPTH_MULT * CONSTRAINT_LEN;
  localparam int SURV_W      = DEPTH_TOTAL * NUM_STATES;
  localparam int PATH_W      = DEPTH_TOTAL * MEM_BITS;

  strobe_t             strobes;
  logic                needTrace, traceEnd, isIdle;
  logic [SURV_W-1:0]   survFlat;
  logic [PATH_W-1:0]   pathFlat;

  cvg_tb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqIn     (reqIn),
    .needTrace (needTrace),
    .traceEnd  (traceEnd),
    .strobes   (strobes),
    .ackOut    (ackOut),
    .isIdle    (isIdle)
  );

  cvg_tb_path #(
    .MEM_BITS    (MEM_BITS),
    .DEPTH       (DEPTH_TOTAL),
    .START_STATE (START_STATE)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .decIn     (decIn),
    .needTrace (needTrace),
    .traceEnd  (traceEnd),
    .bitValid  (bitValid),
    .bitOut    (bitOut),
    .survFlat  (survFlat),
    .pathFlat  (pathFlat)
  );

endmodule

// File: rtl/cvg_traceback_chk.sv
module cvg_traceback_chk #(
  parameter int DEPTH  = 15,
  parameter int SURV_W = 60,
  parameter int PATH_W = 30
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqIn,
  input logic              ackOut,
  input logic              bitValid,
  input logic              isIdle,
  input logic [SURV_W-1:0] survFlat,
  input logic [PATH_W-1:0] pathFlat
);

  // cycles since the edge that accepted the current column
  logic [15:0] cycCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                cycCnt <= '0;
    else if (isIdle && reqIn) cycCnt <= '0;
    else if (cycCnt != 16'hFFFF) cycCnt <= cycCnt + 1'b1;
  end

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> !ackOut);                                               // R9
  AST_ACK_THEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> isIdle);                                                // R9
  AST_VALID_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> ackOut);                                              // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && !reqIn) |=> ($stable(survFlat) && $stable(pathFlat)));  // R10
  AST_TRACE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> (cycCnt <= 16'(DEPTH - 1)));                            // R7

endmodule

bind cvg_traceback cvg_traceback_chk #(
  .DEPTH  (DEPTH_TOTAL),
  .SURV_W (SURV_W),
  .PATH_W (PATH_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqIn    (reqIn),
  .ackOut   (ackOut),
  .bitValid (bitValid),
  .isIdle   (isIdle),
  .survFlat (survFlat),
  .pathFlat (pathFlat)
);

// File: tb/cvg_traceback_tb.sv
`timescale 1ns/1ps
module cvg_traceback_tb;

  localparam int K     = 3;
  localparam int MB    = K - 1;
  localparam int NS    = 1 << MB;
  localparam int DEPTH = 5 * K;
  localparam int START = 0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqIn = 1'b0;
  logic [NS-1:0] decIn = '0;
  logic ackOut, bitValid, bitOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural model state
  int mSurv [DEPTH];
  int mPath [DEPTH];
  int mWp = 0;
  int mFill = 0;
  int mPrimed = 0;
  logic [15:0] lfsr = 16'hACE1;

  cvg_traceback #(.CONSTRAINT_LEN(K), .DEPTH_MULT(5), .START_STATE(START)) u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .decIn(decIn),
    .ackOut(ackOut), .bitValid(bitValid), .bitOut(bitOut)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // model one column: returns steps, bit valid and expected bit
  task automatic modelStep(input int d, output int n, output int bv, output int eb);
    int cur, rp, prev, init;
    mSurv[mWp] = d;
    n = 0;
    bv = 0;
    eb = 0;
    if (!mPrimed && mFill < DEPTH - 1) begin
      mFill++;
    end else begin
      init = !mPrimed;
      mPath[mWp] = START;
      cur = START;
      rp = mWp;
      forever begin
        prev = ((cur << 1) | ((mSurv[rp] >> cur) & 1)) & (NS - 1);
        rp = (rp + DEPTH - 1) % DEPTH;
        n++;
        if (!init && mPath[rp] == prev) break;
        mPath[rp] = prev;
        cur = prev;
        if (n == DEPTH - 1) break;
      end
      bv = 1;
      eb = (mPath[(mWp + 1) % DEPTH] >> (MB - 1)) & 1;
      mPrimed = 1;
    end
    mWp = (mWp + 1) % DEPTH;
  endtask

  // starts and ends at a falling edge; lat is the observed ack delay
  task automatic sendColumn(input int d, input string tag, output int lat);
    int n, bv, eb;
    modelStep(d, n, bv, eb);
    @(negedge clk);
    chk(ackOut == 1'b0, "R9", "ack low before request", ackOut, 0);
    reqIn = 1'b1;
    decIn = NS'(d);
    lat = -1;
    @(posedge clk);
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (ackOut && lat < 0) lat = k;
      if (k < n) begin
        chk(ackOut == 1'b0, tag, "ack during trace", ackOut, 0);
      end else begin
        chk(ackOut == 1'b1, tag, "ack at due cycle", ackOut, 1);
        chk(bitValid == 1'(bv), tag, "R8 bitValid", bitValid, bv);
        if (bv) chk(bitOut == 1'(eb), tag, "R8 bitOut", bitOut, eb);
      end
    end
    reqIn = 1'b0;
  endtask

  function automatic int nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr[3:0]);
  endfunction

  initial begin
    int lat;
    for (int i = 0; i < DEPTH; i++) begin
      mSurv[i] = 0;
      mPath[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(ackOut == 1'b0 && bitValid == 1'b0, "R1", "outputs in reset", {ackOut, bitValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(ackOut == 1'b0 && bitValid == 1'b0, "R1", "outputs after reset", {ackOut, bitValid}, 0);

    // fill phase
    for (int i = 0; i < DEPTH - 1; i++) begin
      sendColumn(nextRand(), "R2", lat);
      chk(lat == 0, "R2", "fill latency", lat, 0);
    end
    // initial full trace
    sendColumn(nextRand(), "R3", lat);
    chk(lat == DEPTH - 1, "R3", "init trace length", lat, DEPTH - 1);

    // mixed decisions, start state and predecessor rule
    for (int i = 0; i < 40; i++) sendColumn(nextRand(), "R4", lat);

    // all-zero decisions: paths merge right away once settled
    for (int i = 0; i < 2 * DEPTH; i++) sendColumn(0, "R5", lat);
    chk(lat == 1, "R5", "merge after one step", lat, 1);

    // idle stretch with toggling decision input
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      decIn = NS'(nextRand());
      chk(ackOut == 1'b0, "R10", "ack while idle", ackOut, 0);
    end

    for (int i = 0; i < 10; i++) sendColumn(NS - 1, "R10", lat);

    // pattern keeps state 0 fixed, other states cycle 1->3->2
    for (int i = 0; i < 2 * DEPTH; i++) sendColumn(6, "R5", lat);
    // state 0 leaves to 1 and never returns: no merge anywhere
    sendColumn(7, "R7", lat);
    chk(lat == DEPTH - 1, "R7", "full depth without match", lat, DEPTH - 1);
    // rewritten entries drain out through the decoded bit
    for (int i = 0; i < DEPTH + 2; i++) sendColumn(6, "R6", lat);

    for (int i = 0; i < 30; i++) sendColumn(nextRand(), "R4", lat);

    @(negedge clk);
    chk(ackOut == 1'b0, "R9", "ack low at end", ackOut, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule